// File: doc/BRIEF.md
# Receive Interrupt Identification Logic

This block turns the fill state of a UART receive FIFO into the status a processor sees for that FIFO. It takes the FIFO occupancy, a two-bit selection of the FIFO threshold, a line-error flag, a character-timeout flag and two enable bits. From these it produces a data-ready bit, a level-sensitive threshold condition, an interrupt identification code and an interrupt line.

The threshold condition is a pure level. It is set while the occupancy is at or above the selected threshold. It drops on its own once reads bring the occupancy below the threshold, so no acknowledge is needed. When several receive sources are pending at once, a fixed priority picks one code for the identification output. All outputs are registered, so they follow the inputs one clock later.

Top module: `rxint_ident`

## Requirements
- R1: `data_ready` is 1 exactly when the occupancy sampled at the previous clock edge was non-zero. It is independent of the enable bits.
- R2: `rda` is 1 when the sampled occupancy is greater than or equal to the threshold. The threshold comes from `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14. `rda` does not depend on the enable bits.
- R3: `rda` returns to 0 on the clock after the occupancy falls below the threshold, with no acknowledge input.
- R4: While receive interrupts are enabled and `line_err` is 1, `int_id` is 8'h06 and `irq` is 1, whatever the other sources are.
- R5: While enabled and without a line error, `int_id` is 8'h04 if `rda` is set. Otherwise it is 8'h0C if `timeout` is 1. When both are present, the threshold code wins.
- R6: When no enabled source is pending, `int_id` is 8'h01 and `irq` is 0. `irq` is 1 exactly when `int_id` differs from 8'h01.
- R7: Unless both `fifo_en` and `rx_int_en` are 1, `int_id` is 8'h01 and `irq` is 0.
- R8: While `rst_n` is low, `data_ready` and `rda` are 0, `int_id` is 8'h01 and `irq` is 0. This takes effect without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| trig_sel | input | 2 | Threshold selection (1, 4, 8, 14) |
| line_err | input | 1 | Line-status error pending |
| timeout | input | 1 | Character timeout pending |
| fifo_en | input | 1 | FIFO mode enable |
| rx_int_en | input | 1 | Receive interrupt enable |
| data_ready | output | 1 | FIFO holds at least one character |
| rda | output | 1 | Occupancy at or above threshold |
| int_id | output | 8 | Prioritized interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are those with an occupancy exactly one below and exactly at each of the four thresholds. These are the only points where a wrong comparison or a wrong threshold value shows up. The vector table walks each threshold through both values in consecutive cycles, which also checks that the condition clears without any acknowledge. It then stacks a line error and a timeout on top of a reached threshold to check the priority order. Enable gating is checked with every source active, so that a missing gate would show on `irq` and `int_id`.

// File: rtl/rxint_pkg.sv
package rxint_pkg;
   localparam logic [7:0] ID_NONE  = 8'h01;
   localparam logic [7:0] ID_LSTAT = 8'h06;
   localparam logic [7:0] ID_DAVAIL = 8'h04;
   localparam logic [7:0] ID_TMO   = 8'h0C;
   localparam int         MAX_TRIG = 14;

   function automatic int trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return MAX_TRIG;
      endcase
   endfunction
endpackage

// File: rtl/rxint_trig_cmp.sv
module rxint_trig_cmp #(
   parameter int CNT_W = 5,
   parameter bit DECODED = 0
) (
   input  logic [CNT_W-1:0] count,
   input  logic [1:0]       sel,
   output logic             at_level
);
   import rxint_pkg::*;

   generate
      if (DECODED) begin : g_decoded
         logic [3:0] hit;
         for (genvar k = 0; k < 4; k++) begin : g_thr
            assign hit[k] = (32'(count) >= 32'(trig_level(2'(k))));
         end
         assign at_level = hit[sel];
      end else begin : g_arith
         assign at_level = (32'(count) >= 32'(trig_level(sel)));
      end
   endgenerate
endmodule

// File: rtl/rxint_prio.sv
module rxint_prio (
   input  logic       enable,
   input  logic       line_err,
   input  logic       level_hit,
   input  logic       timeout,
   output logic [7:0] code,
   output logic       pending
);
   import rxint_pkg::*;

   always_comb begin
      code = ID_NONE;
      if (enable) begin
         if (line_err)       code = ID_LSTAT;
         else if (level_hit) code = ID_DAVAIL;
         else if (timeout)   code = ID_TMO;
      end
      pending = enable & (line_err | level_hit | timeout);
   end
endmodule

// File: rtl/rxint_ident.sv
module rxint_ident #(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
   parameter bit REG_OUT    = 1,
   parameter bit DECODED    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [1:0]       trig_sel,
   input  logic             line_err,
   input  logic             timeout,
   input  logic             fifo_en,
   input  logic             rx_int_en,
   output logic             data_ready,
   output logic             rda,
   output logic [7:0]       int_id,
   output logic             irq
);
   import rxint_pkg::*;

   localparam int MIN_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < MAX_TRIG) begin : g_chk_depth
      $error("FIFO_DEPTH must hold the largest threshold");
   end
   if (CNT_W < MIN_W) begin : g_chk_width
      $error("CNT_W too narrow for FIFO_DEPTH");
   end

   logic       hit_c;
   logic [7:0] code_c;
   logic       pend_c;
   logic       nonempty_c;

   assign nonempty_c = |rx_count;

   rxint_trig_cmp #(.CNT_W(CNT_W), .DECODED(DECODED)) u_cmp (
      .count    (rx_count),
      .sel      (trig_sel),
      .at_level (hit_c)
   );

   rxint_prio u_prio (
      .enable    (fifo_en & rx_int_en),
      .line_err  (line_err),
      .level_hit (hit_c),
      .timeout   (timeout),
      .code      (code_c),
      .pending   (pend_c)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_ready <= 1'b0;
               rda        <= 1'b0;
               int_id     <= ID_NONE;
               irq        <= 1'b0;
            end else begin
               data_ready <= nonempty_c;
               rda        <= hit_c;
               int_id     <= code_c;
               irq        <= pend_c;
            end
         end

         AST_DR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (data_ready == ($past(rx_count) != '0)));          // R1
         AST_RDA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(rx_count) < 32'(trig_level(trig_sel))) |=> !rda);              // R3
         AST_LSTAT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
            (fifo_en && rx_int_en && line_err) |=> (int_id == ID_LSTAT && irq)); // R4
         AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !(fifo_en && rx_int_en) |=> (int_id == ID_NONE && !irq));          // R7
         AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (int_id != ID_NONE));                                        // R6
      end else begin : g_comb
         always_comb begin
            data_ready = rst_n & nonempty_c;
            rda        = rst_n & hit_c;
            int_id     = rst_n ? code_c : ID_NONE;
            irq        = rst_n & pend_c;
         end
      end
   endgenerate
endmodule

// File: tb/test_rxint_ident.sv
module test_rxint_ident;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 5;
   localparam int NV = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] rx_count;
   logic [1:0]    trig_sel;
   logic          line_err, timeout, fifo_en, rx_int_en;
   logic          data_ready, rda, irq;
   logic [7:0]    int_id;

   int n_chk = 0;
   int n_fail = 0;

   rxint_ident i_rxint_ident (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_sel(trig_sel),
      .line_err(line_err), .timeout(timeout), .fifo_en(fifo_en),
      .rx_int_en(rx_int_en), .data_ready(data_ready), .rda(rda),
      .int_id(int_id), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // fields: fe ie trig cnt ls to | dr rda id
   localparam logic [20:0] VEC [NV] = '{
      {1'b1,1'b1,2'd0,5'd0 ,1'b0,1'b0, 1'b0,1'b0,8'h01},  // R1 R6 empty
      {1'b1,1'b1,2'd0,5'd1 ,1'b0,1'b0, 1'b1,1'b1,8'h04},  // R2 thr 1
      {1'b1,1'b1,2'd1,5'd3 ,1'b0,1'b0, 1'b1,1'b0,8'h01},  // R3 below 4
      {1'b1,1'b1,2'd1,5'd4 ,1'b0,1'b0, 1'b1,1'b1,8'h04},  // R2 at 4
      {1'b1,1'b1,2'd2,5'd7 ,1'b0,1'b0, 1'b1,1'b0,8'h01},  // R3 below 8
      {1'b1,1'b1,2'd2,5'd8 ,1'b0,1'b0, 1'b1,1'b1,8'h04},  // R2 at 8
      {1'b1,1'b1,2'd3,5'd13,1'b0,1'b0, 1'b1,1'b0,8'h01},  // R3 below 14
      {1'b1,1'b1,2'd3,5'd14,1'b0,1'b0, 1'b1,1'b1,8'h04},  // R2 at 14
      {1'b1,1'b1,2'd3,5'd16,1'b0,1'b0, 1'b1,1'b1,8'h04},  // R2 full
      {1'b1,1'b1,2'd3,5'd13,1'b1,1'b0, 1'b1,1'b0,8'h06},  // R4 alone
      {1'b1,1'b1,2'd3,5'd14,1'b1,1'b1, 1'b1,1'b1,8'h06},  // R4 over all
      {1'b1,1'b1,2'd3,5'd5 ,1'b0,1'b1, 1'b1,1'b0,8'h0C},  // R5 timeout
      {1'b1,1'b1,2'd0,5'd5 ,1'b0,1'b1, 1'b1,1'b1,8'h04},  // R5 level wins
      {1'b0,1'b1,2'd0,5'd5 ,1'b1,1'b1, 1'b1,1'b1,8'h01},  // R7 fifo off
      {1'b1,1'b0,2'd0,5'd5 ,1'b1,1'b1, 1'b1,1'b1,8'h01},  // R7 ie off
      {1'b1,1'b1,2'd0,5'd0 ,1'b0,1'b0, 1'b0,1'b0,8'h01}   // R6 idle
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic fe, input logic ie, input logic [1:0] ts,
                        input logic [CW-1:0] c, input logic ls, input logic to);
      fifo_en = fe; rx_int_en = ie; trig_sel = ts;
      rx_count = c; line_err = ls; timeout = to;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b1, 1'b1, 2'd0, 5'd9, 1'b1, 1'b1);
      repeat (2) @(negedge clk);
      chk("R8 data_ready", {7'd0, data_ready}, 8'd0);
      chk("R8 rda", {7'd0, rda}, 8'd0);
      chk("R8 int_id", int_id, 8'h01);
      chk("R8 irq", {7'd0, irq}, 8'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][20], VEC[i][19], VEC[i][18:17], VEC[i][16:12], VEC[i][11], VEC[i][10]);
         @(negedge clk);
         chk($sformatf("R1 data_ready vec %0d", i), {7'd0, data_ready}, {7'd0, VEC[i][9]});
         chk($sformatf("R2 R3 rda vec %0d", i), {7'd0, rda}, {7'd0, VEC[i][8]});
         chk($sformatf("R4 R5 R7 int_id vec %0d", i), int_id, VEC[i][7:0]);
         chk($sformatf("R6 irq vec %0d", i), {7'd0, irq}, {7'd0, VEC[i][7:0] != 8'h01});
      end

      // R3: drop from threshold clears with no acknowledge
      drive(1'b1, 1'b1, 2'd2, 5'd9, 1'b0, 1'b0);
      @(negedge clk);
      chk("R2 rda at 9 of 8", {7'd0, rda}, 8'd1);
      rx_count = 5'd8;
      @(negedge clk);
      chk("R2 rda at 8 of 8", {7'd0, rda}, 8'd1);
      rx_count = 5'd7;
      @(negedge clk);
      chk("R3 rda cleared at 7", {7'd0, rda}, 8'd0);
      chk("R3 int_id after clear", int_id, 8'h01);
      // R1: one character sets data_ready, empty clears it
      rx_count = 5'd1;
      @(negedge clk);
      chk("R1 data_ready one char", {7'd0, data_ready}, 8'd1);
      rx_count = 5'd0;
      @(negedge clk);
      chk("R1 data_ready empty", {7'd0, data_ready}, 8'd0);

      // R8: asynchronous reset mid-run
      drive(1'b1, 1'b1, 2'd0, 5'd14, 1'b1, 1'b0);
      @(negedge clk);
      chk("R4 before reset", int_id, 8'h06);
      rst_n = 1'b0;
      #1;
      chk("R8 async int_id", int_id, 8'h01);
      chk("R8 async irq", {7'd0, irq}, 8'd0);
      chk("R8 async rda", {7'd0, rda}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 after reset", int_id, 8'h06);

      summary();
      $finish;
   end
endmodule